// File: doc/BRIEF.md
# Graphics DRAM Command Decoder

This block sits on the command side of a synchronous DRAM that is tuned for graphics use. Each rising clock edge it samples four active-low command pins (chip select, row strobe, column strobe, write enable) plus a fifth input, the special-function flag. With that flag low, every command decodes as it would on a plain synchronous DRAM. With the flag high, three commands change meaning. A mode-register write loads a special register that holds two load-enable flags. A bank activate also turns on per-bit write masking for that bank. A write becomes a block write.

The decoder keeps the state that these variants need. This state is the normal mode word, the two load-enable flags, a per-bank masking enable, and a color word and a mask word taken from the data bus. Masking for a bank stays on until that bank is precharged. While either load-enable flag is set, a write does not reach the array: its data bus word goes into the color register, the mask register, or both. Setting both flags at once leaves the two registers in an undefined state, so the decoder raises a conflict flag. All outputs are registered plain control pins. Each strobe pulses for one cycle, in the cycle after the edge that sampled its command.

Top module: `gdram_cmd_decoder`

## Requirements
- R1: Command pins are read as {cs_n, ras_n, cas_n, we_n}. 0011 is activate, 0101 read, 0100 write, 0010 precharge, 0001 auto refresh, 0000 mode-register write, 0110 burst stop and 0111 no-op. Any value with cs_n high is deselect. A command sampled at edge k drives its strobe high for exactly the one cycle after edge k.
- R2: Deselect and no-op produce no strobe and change no state. The special-function flag has no effect on read, precharge, refresh or burst stop.
- R3: A mode-register write with the flag low pulses mrs_stb and copies addr into mode_q.
- R4: A mode-register write with the flag high pulses smrs_stb and sets load_color_en from addr[6] and load_mask_en from addr[5]. It ignores all other address bits and leaves mode_q unchanged.
- R5: load_conflict is high exactly while both load_color_en and load_mask_en are set.
- R6: An activate sets wpb_q[ba] to the value of the special-function flag. The other banks are not affected.
- R7: A precharge clears wpb_q for bank ba. When addr[10] is high it clears every bank.
- R8: When neither load flag is set, a write pulses bw_stb if the flag is high and wr_stb if it is low. On a write strobe, wr_masked equals wpb_q of the addressed bank before that edge. bank_q always shows the bank input sampled at the previous edge.
- R9: When either load flag is set, a write pulses no write strobe. Instead it copies dq into color_q (if load_color_en is set, pulsing ld_color_stb) and/or into mask_q (if load_mask_en is set, pulsing ld_mask_stb). The flags stay set until the next special mode-register write.
- R10: During reset and after it, all strobes, flags, wpb_q, mode_q, color_q and mask_q are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples commands |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function flag selecting command variants |
| ba | input | BA_W (2) | Bank address |
| addr | input | ADDR_W (11) | Address / mode word |
| dq | input | DATA_W (32) | Data bus for color/mask loads |
| act_stb | output | 1 | Activate strobe |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Normal write strobe |
| bw_stb | output | 1 | Block write strobe |
| pre_stb | output | 1 | Precharge strobe |
| ref_stb | output | 1 | Auto refresh strobe |
| mrs_stb | output | 1 | Normal mode-register write strobe |
| smrs_stb | output | 1 | Special mode-register write strobe |
| bst_stb | output | 1 | Burst stop strobe |
| ld_color_stb | output | 1 | Color register captured dq |
| ld_mask_stb | output | 1 | Mask register captured dq |
| wr_masked | output | 1 | The write uses per-bit masking |
| bank_q | output | BA_W (2) | Bank sampled at previous edge |
| mode_q | output | ADDR_W (11) | Normal mode word |
| load_color_en | output | 1 | Color load flag |
| load_mask_en | output | 1 | Mask load flag |
| load_conflict | output | 1 | Both load flags set |
| wpb_q | output | BANKS (4) | Per-bank masking enable |
| color_q | output | DATA_W (32) | Color register |
| mask_q | output | DATA_W (32) | Mask register |

## Verification
The bound checker checks the following on every cycle. At most one command class strobes at a time. Both kinds of mode-register write reach the right register with the right address bits, and the special one leaves the mode word alone. An activate sets the addressed bank's masking enable to the flag. A flagged write with no load pending becomes a block write. Setting both load bits raises the conflict flag. Some behaviours only the bench's scenarios can show: flags that persist across several writes, data words landing in the color and mask registers, masking surviving writes and then being cleared by single-bank and all-bank precharge, and the flag being ignored on reads, refreshes and burst stops. The bench compares the ports against its reference model after every edge of a long mixed command stream.

// File: rtl/gdram_pkg.sv
package gdram_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MODE,
    CMD_BST
  } cmd_t;
endpackage

// File: rtl/gdram_cmd_dec.sv
module gdram_cmd_dec
  import gdram_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_t cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MODE;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/gdram_spec_regs.sv
module gdram_spec_regs #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  parameter int LC_BIT = 6,
  parameter int LM_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic              spec_we,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq,
  output logic [ADDR_W-1:0] mode_q,
  output logic              lc_q,
  output logic              lm_q,
  output logic [DATA_W-1:0] color_q,
  output logic [DATA_W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      lc_q    <= 1'b0;
      lm_q    <= 1'b0;
      color_q <= '0;
      mask_q  <= '0;
    end else begin
      if (mode_we) mode_q <= addr;
      if (spec_we) begin
        lc_q <= addr[LC_BIT];
        lm_q <= addr[LM_BIT];
      end
      if (cap_en && lc_q) color_q <= dq;
      if (cap_en && lm_q) mask_q  <= dq;
    end
  end
endmodule

// File: rtl/gdram_bank_wpb.sv
module gdram_bank_wpb #(
  parameter int BANKS = 4,
  localparam int BA_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  logic             pre,
  input  logic             pre_all,
  input  logic             dsf,
  input  logic [BA_W-1:0]  ba,
  output logic [BANKS-1:0] wpb_q
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (ba == BA_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n)                    wpb_q[b] <= 1'b0;
      else if (act && hit)           wpb_q[b] <= dsf;
      else if (pre && (pre_all || hit)) wpb_q[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/gdram_cmd_decoder.sv
module gdram_cmd_decoder
  import gdram_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  parameter int LC_BIT = 6,
  parameter int LM_BIT = 5,
  parameter int AP_BIT = 10,
  localparam int BA_W  = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              dsf,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq,
  output logic              act_stb,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              bw_stb,
  output logic              pre_stb,
  output logic              ref_stb,
  output logic              mrs_stb,
  output logic              smrs_stb,
  output logic              bst_stb,
  output logic              ld_color_stb,
  output logic              ld_mask_stb,
  output logic              wr_masked,
  output logic [BA_W-1:0]   bank_q,
  output logic [ADDR_W-1:0] mode_q,
  output logic              load_color_en,
  output logic              load_mask_en,
  output logic              load_conflict,
  output logic [BANKS-1:0]  wpb_q,
  output logic [DATA_W-1:0] color_q,
  output logic [DATA_W-1:0] mask_q
);
  cmd_t cmd;
  logic is_wr, capture, is_mode, is_act, is_pre;

  gdram_cmd_dec u_dec (
    .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .cmd (cmd)
  );

  assign is_wr   = (cmd == CMD_WR);
  assign is_mode = (cmd == CMD_MODE);
  assign is_act  = (cmd == CMD_ACT);
  assign is_pre  = (cmd == CMD_PRE);
  assign capture = is_wr && (load_color_en || load_mask_en);

  gdram_spec_regs #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .LC_BIT (LC_BIT), .LM_BIT (LM_BIT)
  ) u_spec (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_we (is_mode && !dsf),
    .spec_we (is_mode && dsf),
    .cap_en  (capture),
    .addr    (addr),
    .dq      (dq),
    .mode_q  (mode_q),
    .lc_q    (load_color_en),
    .lm_q    (load_mask_en),
    .color_q (color_q),
    .mask_q  (mask_q)
  );

  gdram_bank_wpb #(.BANKS (BANKS)) u_wpb (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (is_act),
    .pre     (is_pre),
    .pre_all (addr[AP_BIT]),
    .dsf     (dsf),
    .ba      (ba),
    .wpb_q   (wpb_q)
  );

  assign load_conflict = load_color_en && load_mask_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_stb      <= 1'b0;
      rd_stb       <= 1'b0;
      wr_stb       <= 1'b0;
      bw_stb       <= 1'b0;
      pre_stb      <= 1'b0;
      ref_stb      <= 1'b0;
      mrs_stb      <= 1'b0;
      smrs_stb     <= 1'b0;
      bst_stb      <= 1'b0;
      ld_color_stb <= 1'b0;
      ld_mask_stb  <= 1'b0;
      wr_masked    <= 1'b0;
      bank_q       <= '0;
    end else begin
      act_stb      <= is_act;
      rd_stb       <= (cmd == CMD_RD);
      wr_stb       <= is_wr && !capture && !dsf;
      bw_stb       <= is_wr && !capture && dsf;
      pre_stb      <= is_pre;
      ref_stb      <= (cmd == CMD_REF);
      mrs_stb      <= is_mode && !dsf;
      smrs_stb     <= is_mode && dsf;
      bst_stb      <= (cmd == CMD_BST);
      ld_color_stb <= capture && load_color_en;
      ld_mask_stb  <= capture && load_mask_en;
      wr_masked    <= is_wr && !capture && wpb_q[ba];
      bank_q       <= ba;
    end
  end
endmodule

// File: rtl/gdram_cmd_decoder_chk.sv
module gdram_cmd_decoder_chk #(
  parameter int BANKS  = 4,
  parameter int ADDR_W = 11,
  parameter int LC_BIT = 6,
  parameter int LM_BIT = 5,
  localparam int BA_W  = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              dsf,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              act_stb,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic              bw_stb,
  input logic              pre_stb,
  input logic              ref_stb,
  input logic              mrs_stb,
  input logic              smrs_stb,
  input logic              bst_stb,
  input logic              ld_color_stb,
  input logic              ld_mask_stb,
  input logic [ADDR_W-1:0] mode_q,
  input logic              load_color_en,
  input logic              load_mask_en,
  input logic              load_conflict,
  input logic [BANKS-1:0]  wpb_q
);
  logic mode_cmd, act_cmd, wr_cmd;
  assign mode_cmd = !cs_n && !ras_n && !cas_n && !we_n;
  assign act_cmd  = !cs_n && !ras_n && cas_n && we_n;
  assign wr_cmd   = !cs_n && ras_n && !cas_n && !we_n;

  // R1
  one_cmd_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_stb, rd_stb, wr_stb, bw_stb, pre_stb, ref_stb, mrs_stb,
              smrs_stb, bst_stb, (ld_color_stb || ld_mask_stb)}));

  // R3
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cmd && !dsf) |=> (mrs_stb && !smrs_stb && mode_q == $past(addr)));

  // R4
  spec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cmd && dsf) |=> (smrs_stb && !mrs_stb && $stable(mode_q)
      && load_color_en == $past(addr[LC_BIT])
      && load_mask_en == $past(addr[LM_BIT])));

  // R5
  conflict_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cmd && dsf && addr[LC_BIT] && addr[LM_BIT]) |=> load_conflict);

  // R6
  act_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_cmd |=> (act_stb && wpb_q[$past(ba)] == $past(dsf)));

  // R8
  block_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && dsf && !load_color_en && !load_mask_en) |=> (bw_stb && !wr_stb));

  // R9
  capture_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && (load_color_en || load_mask_en)) |=> (!wr_stb && !bw_stb));
endmodule

bind gdram_cmd_decoder gdram_cmd_decoder_chk #(
  .BANKS (BANKS), .ADDR_W (ADDR_W), .LC_BIT (LC_BIT), .LM_BIT (LM_BIT)
) u_chk (.*);

// File: tb/sim_gdram_cmd_decoder.sv
module sim_gdram_cmd_decoder;
  localparam int BANKS = 4, BA_W = 2, ADDR_W = 11, DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0;
  logic [BA_W-1:0] ba = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dq = '0;
  logic act_stb, rd_stb, wr_stb, bw_stb, pre_stb, ref_stb, mrs_stb, smrs_stb, bst_stb;
  logic ld_color_stb, ld_mask_stb, wr_masked, load_color_en, load_mask_en, load_conflict;
  logic [BA_W-1:0] bank_q;
  logic [ADDR_W-1:0] mode_q;
  logic [BANKS-1:0] wpb_q;
  logic [DATA_W-1:0] color_q, mask_q;

  always #10 clk = ~clk;

  gdram_cmd_decoder u0 (.*);

  int n_cmp = 0, n_bad = 0;

  // reference model state and expectations
  logic [ADDR_W-1:0] m_mode = '0;
  logic m_lc = 0, m_lm = 0;
  logic [DATA_W-1:0] m_color = '0, m_mask = '0;
  logic [BANKS-1:0] m_wpb = '0;
  logic [BA_W-1:0] e_bank = '0;
  logic e_act = 0, e_rd = 0, e_wr = 0, e_bw = 0, e_pre = 0, e_ref = 0;
  logic e_mrs = 0, e_smrs = 0, e_bst = 0, e_ldc = 0, e_ldm = 0, e_msk = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R1 R2 act/rd/pre/ref/bst", {act_stb, rd_stb, pre_stb, ref_stb, bst_stb},
        {e_act, e_rd, e_pre, e_ref, e_bst});
    chk("R3 mrs_stb", mrs_stb, e_mrs);
    chk("R3 mode_q", mode_q, m_mode);
    chk("R4 smrs_stb", smrs_stb, e_smrs);
    chk("R4 load flags", {load_color_en, load_mask_en}, {m_lc, m_lm});
    chk("R5 load_conflict", load_conflict, m_lc & m_lm);
    chk("R6 R7 wpb_q", wpb_q, m_wpb);
    chk("R8 wr/bw strobes", {wr_stb, bw_stb}, {e_wr, e_bw});
    chk("R8 wr_masked", wr_masked, e_msk);
    chk("R8 bank_q", bank_q, e_bank);
    chk("R9 load strobes", {ld_color_stb, ld_mask_stb}, {e_ldc, e_ldm});
    chk("R9 color_q", color_q, m_color);
    chk("R9 mask_q", mask_q, m_mask);
  endtask

  // drive one command for one cycle, then update the model
  task automatic issue(input logic [3:0] c, input logic f, input logic [BA_W-1:0] b,
                       input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    compare();
    {cs_n, ras_n, cas_n, we_n} = c;
    dsf = f; ba = b; addr = a; dq = d;
    {e_act, e_rd, e_wr, e_bw, e_pre, e_ref, e_mrs, e_smrs, e_bst, e_ldc, e_ldm, e_msk} = '0;
    e_bank = b;
    if (!c[3]) begin
      case (c[2:0])
        3'b011: begin e_act = 1; m_wpb[b] = f; end
        3'b101: e_rd = 1;
        3'b100: begin
          if (m_lc || m_lm) begin
            if (m_lc) begin e_ldc = 1; m_color = d; end
            if (m_lm) begin e_ldm = 1; m_mask = d; end
          end else begin
            if (f) e_bw = 1; else e_wr = 1;
            e_msk = m_wpb[b];
          end
        end
        3'b010: begin
          e_pre = 1;
          if (a[10]) m_wpb = '0; else m_wpb[b] = 1'b0;
        end
        3'b001: e_ref = 1;
        3'b000: begin
          if (f) begin e_smrs = 1; m_lc = a[6]; m_lm = a[5]; end
          else begin e_mrs = 1; m_mode = a; end
        end
        3'b110: e_bst = 1;
        default: ;
      endcase
    end
  endtask

  localparam logic [3:0] C_DES = 4'b1000, C_NOP = 4'b0111, C_ACT = 4'b0011,
    C_RD = 4'b0101, C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
    C_MODE = 4'b0000, C_BST = 4'b0110;

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs during reset
    chk("R10 strobes in reset", {act_stb, rd_stb, wr_stb, bw_stb, mrs_stb, smrs_stb}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 state after reset", {wpb_q, load_color_en, load_mask_en, mode_q}, '0);
    chk("R10 color/mask after reset", {color_q, mask_q}, '0);

    issue(C_NOP, 1, 2, 11'h7ff, 32'hffff_ffff);            // R2
    issue(C_DES, 1, 3, 11'h000, 32'h1);                    // R2
    issue(4'b1100, 1, 1, 11'h060, 32'h2);                  // R2 deselect with write pins
    issue(C_MODE, 0, 0, 11'h232, 32'h0);                   // R3
    issue(C_MODE, 1, 0, 11'h79f, 32'h0);                   // R4 lc=0 lm=0, other bits set
    issue(C_MODE, 1, 1, 11'h040, 32'h0);                   // R4 color load
    issue(C_WR, 0, 2, 11'h003, 32'hcafe_f00d);             // R9
    issue(C_WR, 1, 3, 11'h004, 32'h1234_5678);             // R9 persists
    issue(C_MODE, 1, 0, 11'h020, 32'h0);                   // R4 mask load
    issue(C_WR, 1, 0, 11'h000, 32'h0f0f_00ff);             // R9
    issue(C_MODE, 1, 0, 11'h000, 32'h0);                   // clear flags
    issue(C_ACT, 1, 1, 11'h155, 32'h0);                    // R6 masked bank 1
    issue(C_WR, 1, 1, 11'h010, 32'h0);                     // R8 block write masked
    issue(C_WR, 0, 1, 11'h011, 32'h0);                     // R8 normal write masked
    issue(C_ACT, 0, 2, 11'h0aa, 32'h0);                    // R6 unmasked bank 2
    issue(C_WR, 0, 2, 11'h012, 32'h0);                     // R8 unmasked
    issue(C_RD, 1, 1, 11'h000, 32'h0);                     // R2 dsf ignored
    issue(C_REF, 1, 0, 11'h000, 32'h0);                    // R2
    issue(C_BST, 1, 0, 11'h000, 32'h0);                    // R2
    issue(C_PRE, 1, 2, 11'h000, 32'h0);                    // R7 single bank (other)
    issue(C_WR, 0, 1, 11'h000, 32'h0);                     // R8 still masked
    issue(C_PRE, 0, 1, 11'h000, 32'h0);                    // R7
    issue(C_WR, 1, 1, 11'h000, 32'h0);                     // R8 unmasked now
    issue(C_ACT, 1, 0, 11'h000, 32'h0);
    issue(C_ACT, 1, 3, 11'h000, 32'h0);
    issue(C_PRE, 0, 2, 11'h400, 32'h0);                    // R7 all banks
    issue(C_MODE, 1, 0, 11'h060, 32'h0);                   // R5 conflict
    issue(C_WR, 0, 0, 11'h000, 32'hdead_beef);             // R9 both load
    issue(C_MODE, 0, 0, 11'h000, 32'h0);                   // R3 with flags
    for (int i = 0; i < 600; i++) begin
      logic [3:0] c;
      c = 4'($urandom_range(0, 15));
      if (c[2:0] == 3'b000 && !c[3] && ($urandom_range(0, 3) != 0)) c = C_NOP;
      issue(c, 1'($urandom), 2'($urandom), 11'($urandom), $urandom);
    end
    issue(C_NOP, 0, 0, 11'h0, 32'h0);
    @(negedge clk);
    compare();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule